// File: doc/BRIEF.md
# Dual Programmable Timer with Shared Interrupt

This block holds two independent down-counting timers behind a small 32-bit register bus. Each timer has its own divisor register and control register. The control register carries a two-bit opcode and a three-bit source-select code:

- The opcode either copies the divisor into the counter, freezes the counter, or lets it run periodically.
- The source-select code picks one of four tick-enable inputs. Each input stands for one of the nominal source rates, which are about 29.49 MHz, 32 MHz, 32.768 MHz and 100 MHz. Those clocks are generated elsewhere.

When a running counter reaches its terminal value, it reloads from the divisor and sets its own bit in a raw pending register. A mask register routes the pending bits onto a single active-high interrupt line. Writing ones to the acknowledge register clears pending bits.

Software first writes a divisor. It then issues a load followed by a run, and services the interrupt by acknowledging the bit of the timer that fired.

Top module: `duo_timer_ic`

## Requirements
- R1: While the active-low reset is asserted, and immediately after it is released, both timers are stopped with a count of 0, and the control, divisor, pending and mask registers read 0. The interrupt output is low.
- R2: Writing a control value with opcode bits [1:0] = 0 (load) copies the current divisor into that timer's count and stops the timer.
- R3: Opcode 2 (run) starts the timer. A running timer changes its count only in a cycle where the tick input chosen by its source code (bits [4:2]) is high. Codes 4, 5, 6 and 7 select src_tick[0], [1], [2] and [3]. Each such tick lowers the count by one.
- R4: A tick that finds a running count of 1 or less is an expiry. The count reloads from the divisor, and pending bit n (timer n) is set. A divisor of D therefore gives one expiry every D ticks.
- R5: Opcode 1 (hold) stops the timer. Ticks then leave its count unchanged.
- R6: Writing a divisor register leaves a running count untouched. The new value takes effect at the next load or reload.
- R7: A control write with opcode 3, or with a source code below 4, is ignored. The stored control value and the timer state stay as they were.
- R8: The interrupt output is high exactly when some pending bit and its mask bit are both set. It follows mask writes on the next cycle.
- R9: Writing the acknowledge register clears each pending bit written as 1. If an expiry of the same timer happens in the same cycle, the pending bit stays set.
- R10: Register offsets are as follows:
  - Timer 0 divisor 0x00 and control 0x08.
  - Timer 1 divisor 0x10 and control 0x18.
  - Count readback of timer 0 at 0x38 and of timer 1 at 0x3C.
  - Mask 0x48, acknowledge 0x4C, pending 0x50.
  - Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_tick | input | 4 | Tick enables of the four selectable source rates |
| irq | output | 1 | Shared interrupt line |

## Verification
The hardest case to reach from the ports is an expiry that lands in the same cycle as an acknowledge of that same timer. The bench runs timer 1 down to a count of 1 one tick at a time, reading the count back after each tick. It then raises the selected tick in the very cycle that carries the acknowledge write, and expects the pending bit to survive. Divisor rewrites during a run, and control writes with a bad opcode or a bad source code, are likewise set up only when the count sits at a known value. Their lack of effect is then read back through the count and control offsets.

// File: rtl/duo_tmr_pkg.sv
package duo_tmr_pkg;
  localparam int N_TMR  = 2;
  localparam int N_SRC  = 4;
  localparam int ADDR_W = 8;
  localparam int CTRL_W = 5;
  localparam int SRC_W  = $clog2(N_SRC);

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_ACK  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h38;

  function automatic logic [ADDR_W-1:0] off_div(int n);
    return ADDR_W'(n * 16);
  endfunction

  function automatic logic [ADDR_W-1:0] off_ctrl(int n);
    return ADDR_W'(n * 16 + 8);
  endfunction

  function automatic logic [ADDR_W-1:0] off_cnt(int n);
    return ADDR_W'(OFF_CNT + ADDR_W'(n * 4));
  endfunction

  // Legal control word: source code 4..7 and an opcode other than 3.
  function automatic logic ctrl_ok(logic [CTRL_W-1:0] v);
    return v[4] && (v[1:0] != OP_BAD);
  endfunction

  // Source code 4..7 maps onto tick input 0..3.
  function automatic logic [SRC_W-1:0] src_of(logic [CTRL_W-1:0] v);
    return v[SRC_W+1:2];
  endfunction
endpackage

// File: rtl/duo_tmr_chan.sv
module duo_tmr_chan
  import duo_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  tmr_op_e          op,
  input  logic [SRC_W-1:0] sel,
  input  logic [CNT_W-1:0] div,
  input  logic [N_SRC-1:0] src_tick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tick;

  assign tick    = src_tick[sel];
  assign expire  = run_q && tick && !ctrl_we && (cnt_q <= CNT_W'(1));
  assign count   = cnt_q;
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ctrl_we) begin
      case (op)
        OP_LOAD: begin cnt_q <= div; run_q <= 1'b0; end
        OP_HOLD: run_q <= 1'b0;
        OP_RUN:  run_q <= 1'b1;
        default: ;
      endcase
    end else if (run_q && tick) begin
      cnt_q <= expire ? div : cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/duo_tmr_irq.sv
module duo_tmr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         mask_we,
  input  logic         ack_we,
  input  logic [N-1:0] wval,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr;

  assign clr  = ack_we ? wval : '0;
  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | set;
      if (mask_we) mask_q <= wval;
    end
  end
endmodule

// File: rtl/duo_timer_ic.sv
module duo_timer_ic
  import duo_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_SRC-1:0]  src_tick,
  output logic              irq
);
  logic [N_TMR-1:0][CNT_W-1:0]  div_q;
  logic [N_TMR-1:0][CTRL_W-1:0] ctrl_q;
  logic [N_TMR-1:0][CNT_W-1:0]  cnt_w;
  logic [N_TMR-1:0]             cwe;
  logic [N_TMR-1:0]             run_w;
  logic [N_TMR-1:0]             exp_w;
  logic [N_TMR-1:0]             raw_w;
  logic [N_TMR-1:0]             mask_w;
  logic                         mask_we;
  logic                         ack_we;

  assign mask_we = wr_en && (addr == OFF_MASK);
  assign ack_we  = wr_en && (addr == OFF_ACK);

  always_comb begin
    for (int n = 0; n < N_TMR; n++)
      cwe[n] = wr_en && (addr == off_ctrl(n)) && ctrl_ok(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
    end else begin
      for (int n = 0; n < N_TMR; n++) begin
        if (wr_en && addr == off_div(n)) div_q[n] <= wdata[CNT_W-1:0];
        if (cwe[n]) ctrl_q[n] <= wdata[CTRL_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_chan
    duo_tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (cwe[g]),
      .op       (tmr_op_e'(wdata[1:0])),
      .sel      (src_of(ctrl_q[g])),
      .div      (div_q[g]),
      .src_tick (src_tick),
      .count    (cnt_w[g]),
      .running  (run_w[g]),
      .expire   (exp_w[g])
    );
  end

  duo_tmr_irq #(.N(N_TMR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (exp_w),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wval    (wdata[N_TMR-1:0]),
    .raw     (raw_w),
    .mask    (mask_w),
    .irq     (irq)
  );

  always_comb begin
    rdata = '0;
    for (int n = 0; n < N_TMR; n++) begin
      if (addr == off_div(n))  rdata = DATA_W'(div_q[n]);
      if (addr == off_ctrl(n)) rdata = DATA_W'(ctrl_q[n]);
      if (addr == off_cnt(n))  rdata = DATA_W'(cnt_w[n]);
    end
    if (addr == OFF_MASK) rdata = DATA_W'(mask_w);
    if (addr == OFF_RAW)  rdata = DATA_W'(raw_w);
  end
endmodule

// File: rtl/duo_timer_ic_chk.sv
module duo_timer_ic_chk
  import duo_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            wdata,
  input logic                         irq,
  input logic [N_TMR-1:0]             raw,
  input logic [N_TMR-1:0]             mask,
  input logic [N_TMR-1:0]             expire,
  input logic [N_TMR-1:0]             cwe,
  input logic [N_TMR-1:0]             running,
  input logic [N_TMR-1:0][CNT_W-1:0]  cnt,
  input logic [N_TMR-1:0][CNT_W-1:0]  div,
  input logic [N_TMR-1:0][CTRL_W-1:0] ctrl
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (raw == '0 && mask == '0 && !irq && running == '0)); // R1

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cwe[0] && wdata[1:0] == 2'd0) |=> (cnt[0] == $past(div[0]) && !running[0])); // R2

  AST_RAW_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> raw[0]); // R4

  AST_RAW1_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |=> raw[1]); // R9

  AST_RELOAD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> cnt[0] == $past(div[0])); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running[0] && !cwe[0]) |=> $stable(cnt[0])); // R5

  AST_BAD_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h08 && !ctrl_ok(wdata[CTRL_W-1:0])) |=> $stable(ctrl[0])); // R7

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R8
endmodule

bind duo_timer_ic duo_timer_ic_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq     (irq),
  .raw     (raw_w),
  .mask    (mask_w),
  .expire  (exp_w),
  .cwe     (cwe),
  .running (run_w),
  .cnt     (cnt_w),
  .div     (div_q),
  .ctrl    (ctrl_q)
);

// File: tb/duo_timer_ic_tb.sv
`timescale 1ns/1ps
module duo_timer_ic_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [3:0]  src_tick = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;
  exp_t sb[$];
  event go;

  localparam logic [7:0] PIN_IRQ = 8'hFF;

  always #4 clk = ~clk;

  duo_timer_ic u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_tick(src_tick), .irq(irq)
  );

  // Monitor: pops the expected item and compares it to the observed value.
  initial begin
    forever begin
      @(go);
      #1;
      begin
        exp_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.a == PIN_IRQ) ? {31'b0, irq} : rdata;
        n_chk++;
        if (act !== it.e) begin
          n_fail++;
          $display("FAIL %s: offset %h actual %h expected %h", it.tag, it.a, act, it.e);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a;
    sb.push_back('{a: a, e: e, tag: tag});
    ->go;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int idx);
    src_tick[idx] = 1'b1;
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic wr_tk(input logic [7:0] a, input logic [31:0] d, input int idx);
    wr_en = 1'b1; addr = a; wdata = d; src_tick[idx] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; src_tick = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1..R10 run): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(8'h50, 32'h0, "R1 pending in reset");
    chk(PIN_IRQ, 32'h0, "R1 irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h50, 32'h0, "R1 pending after reset");
    chk(8'h48, 32'h0, "R1 mask after reset");
    chk(8'h38, 32'h0, "R1 count0 after reset");
    chk(8'h08, 32'h0, "R1 ctrl0 after reset");
    chk(8'h44, 32'h0, "R10 unmapped reads zero");

    // Timer 0: divisor 3, load with source code 4, then run.
    wr(8'h00, 32'd3);
    chk(8'h00, 32'd3, "R10 divisor0 readback");
    wr(8'h08, 32'h10);
    chk(8'h38, 32'd3, "R2 load copies divisor");
    tk(0);
    chk(8'h38, 32'd3, "R2 load leaves timer stopped");
    wr(8'h08, 32'h12);
    chk(8'h08, 32'h12, "R10 ctrl0 readback");
    tk(0);
    chk(8'h38, 32'd2, "R3 run decrements on source 4");
    tk(1);
    tk(2);
    tk(3);
    chk(8'h38, 32'd2, "R3 other sources ignored");
    tk(0);
    chk(8'h38, 32'd1, "R3 second tick");
    chk(8'h50, 32'h0, "R4 no expiry yet");
    tk(0);
    chk(8'h50, 32'h1, "R4 expiry sets pending bit 0");
    chk(8'h38, 32'd3, "R4 reload from divisor");
    chk(PIN_IRQ, 32'h0, "R8 masked off");
    wr(8'h48, 32'h1);
    chk(PIN_IRQ, 32'h1, "R8 irq after mask write");
    wr(8'h4C, 32'h1);
    chk(8'h50, 32'h0, "R9 ack clears bit 0");
    chk(PIN_IRQ, 32'h0, "R8 irq low after ack");

    // Divisor change while running.
    wr(8'h00, 32'd5);
    chk(8'h38, 32'd3, "R6 divisor write keeps count");
    tk(0);
    tk(0);
    chk(8'h38, 32'd1, "R6 count continues from old value");
    tk(0);
    chk(8'h38, 32'd5, "R6 new divisor used at reload");
    chk(PIN_IRQ, 32'h1, "R8 irq on second expiry");

    // Hold and illegal control words.
    wr(8'h08, 32'h11);
    tk(0);
    chk(8'h38, 32'd5, "R5 hold freezes count");
    wr(8'h08, 32'h13);
    chk(8'h08, 32'h11, "R7 opcode 3 ignored");
    wr(8'h08, 32'h02);
    chk(8'h08, 32'h11, "R7 source code 0 ignored");
    tk(0);
    chk(8'h38, 32'd5, "R7 illegal run did not start timer");
    wr(8'h4C, 32'h1);

    // Timer 1: divisor 2, source code 7.
    wr(8'h10, 32'd2);
    wr(8'h18, 32'h1C);
    chk(8'h3C, 32'd2, "R2 timer1 load");
    wr(8'h18, 32'h1E);
    tk(3);
    chk(8'h3C, 32'd1, "R3 timer1 on source 7");
    tk(3);
    chk(8'h50, 32'h2, "R4 timer1 sets pending bit 1");
    chk(PIN_IRQ, 32'h0, "R8 bit1 not masked");
    wr(8'h48, 32'h3);
    chk(PIN_IRQ, 32'h1, "R8 bit1 masked in");
    wr(8'h4C, 32'h1);
    chk(8'h50, 32'h2, "R9 ack of bit0 keeps bit1");
    wr(8'h4C, 32'h2);
    chk(8'h50, 32'h0, "R9 ack clears bit1");

    // Acknowledge in the same cycle as an expiry.
    tk(3);
    chk(8'h3C, 32'd1, "R9 setup count 1");
    wr_tk(8'h4C, 32'h2, 3);
    chk(8'h50, 32'h2, "R9 expiry wins over ack");
    chk(8'h3C, 32'd2, "R4 timer1 reload");

    // Reset while active.
    rst_n = 1'b0;
    @(negedge clk);
    chk(8'h50, 32'h0, "R1 pending cleared by reset");
    chk(8'h48, 32'h0, "R1 mask cleared by reset");
    chk(PIN_IRQ, 32'h0, "R1 irq low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    tk(3);
    chk(8'h3C, 32'd0, "R1 timer1 stopped after reset");

    done = 1;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule